// File: doc/BRIEF.md
# FP8 to single-precision widening converter

This block takes one 8-bit floating-point operand per clock and widens it to an IEEE 754 single-precision word. A format-select bit picks, for each operand, one of two 8-bit layouts: a layout with a 4-bit exponent and a 3-bit mantissa, or a layout with a 5-bit exponent and a 2-bit mantissa. Every value either layout can hold has an exact single-precision equivalent, so the conversion never rounds.

The 5-bit-exponent layout reserves its all-ones exponent for infinities and NaNs in the usual IEEE way. The 4-bit-exponent layout gives up infinities altogether and keeps a single NaN code, so all of its other all-ones-exponent codes remain finite values. Subnormal inputs are renormalised into normal single-precision numbers. Alongside the result the block reports which class the input belonged to.

The port has no handshake. A valid strobe comes in with the operand, and the registered result, its class flags and a delayed valid strobe appear on the next clock.

Top module: `fp8w_widen`

## Requirements
- R1: With `in_fmt` = 0, the operand is sign in bit 7, exponent in bits 6:3 (bias 7) and mantissa in bits 2:0. A nonzero exponent below 15, or exponent 15 with a mantissa other than 7, converts to sign, exponent field + 120, and the mantissa in result bits 22:20 with zeros below.
- R2: With `in_fmt` = 1, the operand is sign in bit 7, exponent in bits 6:2 (bias 15) and mantissa in bits 1:0. An exponent from 1 to 30 converts to sign, exponent field + 112, and the mantissa in result bits 22:21 with zeros below.
- R3: A zero exponent with a nonzero mantissa is subnormal in either layout. The result is the exactly equal normal single-precision number, with the leading one made implicit. Only `out_sub` is raised.
- R4: A zero exponent with a zero mantissa gives a single-precision zero (bits 30:0 all zero) that keeps the input sign. Only `out_zero` is raised.
- R5: With `in_fmt` = 1, exponent 31 with mantissa 0 gives infinity of the input sign (exponent 0xFF, mantissa zero). Only `out_inf` is raised.
- R6: With `in_fmt` = 1, exponent 31 with a nonzero mantissa gives a quiet NaN: input sign, exponent 0xFF, mantissa bit 22 set, bits 21:0 zero. Only `out_nan` is raised.
- R7: With `in_fmt` = 0, only exponent 15 with mantissa 7 is NaN, of either sign, with the same quiet-NaN output as R6. Exponent 15 with mantissa 6 is the largest finite magnitude, 448 (0x43E00000 when positive). `out_inf` is never raised in this layout.
- R8: `out_valid` equals `in_valid` delayed by one clock. A synchronous active-high `rst` clears `out_valid`.
- R9: While `in_valid` is low, `out_data` and the class flags keep their previous values.
- R10: At most one class flag is high at a time. A normal finite input raises none of them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operand present this cycle |
| in_fmt | input | 1 | 0: 4-bit-exponent layout, 1: 5-bit-exponent layout |
| in_data | input | 8 | FP8 operand |
| out_valid | output | 1 | Result present this cycle |
| out_data | output | 32 | Single-precision result |
| out_zero | output | 1 | Operand was a signed zero |
| out_sub | output | 1 | Operand was subnormal |
| out_inf | output | 1 | Operand was an infinity |
| out_nan | output | 1 | Operand was a NaN |

## Verification
The only state is the one-cycle output register, so any internal fault shows at the ports on the clock after the operand that triggers it. A leading-zero count that is off, or a bias chosen for the wrong layout, shifts the exponent of every subnormal or normal code of that layout. A misclassified all-ones exponent shows up as a flag on the wrong port and an exponent field of 0xFF where a finite value belongs, or the reverse. Because every operand code in both layouts is applied, each such fault is seen within a few hundred cycles of the start of the sweep.

// File: rtl/fp8w_pkg.sv
package fp8w_pkg;

  localparam int IN_W      = 8;
  localparam int OUT_W     = 32;
  localparam int OUT_EXP_W = 8;
  localparam int OUT_MAN_W = 23;
  localparam int OUT_BIAS  = 127;

  localparam int NX_EXP_W  = 4;
  localparam int NX_MAN_W  = 3;
  localparam int NX_BIAS   = 7;
  localparam int WX_EXP_W  = 5;
  localparam int WX_MAN_W  = 2;
  localparam int WX_BIAS   = 15;

  localparam int UEXP_W = (NX_EXP_W > WX_EXP_W) ? NX_EXP_W : WX_EXP_W;
  localparam int UMAN_W = (NX_MAN_W > WX_MAN_W) ? NX_MAN_W : WX_MAN_W;
  localparam int LZ_W   = $clog2(UMAN_W + 1);
  localparam int EW1    = OUT_EXP_W + 1;

  typedef enum logic {
    FMT_EXP4 = 1'b0,
    FMT_EXP5 = 1'b1
  } fp8w_fmt_e;

  typedef enum logic [2:0] {
    CLS_ZERO = 3'd0,
    CLS_SUB  = 3'd1,
    CLS_NORM = 3'd2,
    CLS_INF  = 3'd3,
    CLS_NAN  = 3'd4
  } fp8w_cls_e;

  typedef struct packed {
    logic              sign;
    logic [UEXP_W-1:0] exp;
    logic [UMAN_W-1:0] man;
    logic [UEXP_W-1:0] bias;
    fp8w_cls_e         cls;
  } fp8w_unp_t;

  typedef struct packed {
    logic zero;
    logic sub;
    logic inf;
    logic nan;
  } fp8w_flags_t;

  function automatic logic [OUT_EXP_W-1:0] f_norm_exp(
    input logic [UEXP_W-1:0] exp,
    input logic [UEXP_W-1:0] bias
  );
    logic [EW1-1:0] t;
    t = EW1'(OUT_BIAS) + EW1'(exp) - EW1'(bias);
    return t[OUT_EXP_W-1:0];
  endfunction

  function automatic logic [OUT_EXP_W-1:0] f_sub_exp(
    input logic [UEXP_W-1:0] bias,
    input logic [LZ_W-1:0]   lz
  );
    logic [EW1-1:0] t;
    t = EW1'(OUT_BIAS) - EW1'(bias) - EW1'(lz);
    return t[OUT_EXP_W-1:0];
  endfunction

  function automatic logic [UMAN_W-1:0] f_sub_man(
    input logic [UMAN_W-1:0] man,
    input logic [LZ_W-1:0]   lz
  );
    logic [UMAN_W:0] t;
    t = {1'b0, man} << (lz + 1);
    return t[UMAN_W-1:0];
  endfunction

  function automatic logic [OUT_MAN_W-1:0] f_pad_man(input logic [UMAN_W-1:0] man);
    return OUT_MAN_W'(man) << (OUT_MAN_W - UMAN_W);
  endfunction

endpackage

// File: rtl/fp8w_fmt_dec.sv
module fp8w_fmt_dec
  import fp8w_pkg::*;
#(
  parameter int EXP_W   = 4,
  parameter int MAN_W   = 3,
  parameter int BIAS    = 7,
  parameter bit HAS_INF = 1'b0
) (
  input  logic [IN_W-1:0] byte_i,
  output fp8w_unp_t       unp_o
);

  logic [EXP_W-1:0] exp_f;
  logic [MAN_W-1:0] man_f;
  logic             exp_ones;
  logic             exp_zero;
  logic             man_nz;
  logic             man_ones;
  fp8w_cls_e        cls;

  assign exp_f    = byte_i[IN_W-2 -: EXP_W];
  assign man_f    = byte_i[MAN_W-1:0];
  assign exp_ones = &exp_f;
  assign exp_zero = ~|exp_f;
  assign man_nz   = |man_f;
  assign man_ones = &man_f;

  generate
    if (HAS_INF) begin : g_ieee_special
      always_comb begin
        if (exp_ones)      cls = man_nz ? CLS_NAN : CLS_INF;
        else if (exp_zero) cls = man_nz ? CLS_SUB : CLS_ZERO;
        else               cls = CLS_NORM;
      end
    end else begin : g_ext_range
      always_comb begin
        if (exp_ones && man_ones) cls = CLS_NAN;
        else if (exp_zero)        cls = man_nz ? CLS_SUB : CLS_ZERO;
        else                      cls = CLS_NORM;
      end
    end
  endgenerate

  always_comb begin
    unp_o.sign = byte_i[IN_W-1];
    unp_o.exp  = UEXP_W'(exp_f);
    unp_o.man  = UMAN_W'(man_f) << (UMAN_W - MAN_W);
    unp_o.bias = UEXP_W'(BIAS);
    unp_o.cls  = cls;
  end

endmodule

// File: rtl/fp8w_lzc.sv
module fp8w_lzc #(
  parameter int W   = 3,
  localparam int CW = $clog2(W + 1)
) (
  input  logic [W-1:0]  vec_i,
  output logic [CW-1:0] lz_o
);

  always_comb begin
    lz_o = CW'(W);
    for (int i = 0; i < W; i++) begin
      if (vec_i[i]) lz_o = CW'(W - 1 - i);
    end
  end

endmodule

// File: rtl/fp8w_pack.sv
module fp8w_pack
  import fp8w_pkg::*;
(
  input  fp8w_unp_t        unp_i,
  input  logic [LZ_W-1:0]  lz_i,
  output logic [OUT_W-1:0] word_o,
  output fp8w_flags_t      flags_o
);

  localparam logic [OUT_EXP_W-1:0] EXP_MAX = '1;

  always_comb begin
    flags_o = '0;
    unique case (unp_i.cls)
      CLS_ZERO: begin
        word_o       = {unp_i.sign, {(OUT_W-1){1'b0}}};
        flags_o.zero = 1'b1;
      end
      CLS_SUB: begin
        word_o = {unp_i.sign, f_sub_exp(unp_i.bias, lz_i),
                  f_pad_man(f_sub_man(unp_i.man, lz_i))};
        flags_o.sub = 1'b1;
      end
      CLS_INF: begin
        word_o      = {unp_i.sign, EXP_MAX, {OUT_MAN_W{1'b0}}};
        flags_o.inf = 1'b1;
      end
      CLS_NAN: begin
        word_o      = {unp_i.sign, EXP_MAX, 1'b1, {(OUT_MAN_W-1){1'b0}}};
        flags_o.nan = 1'b1;
      end
      default: begin
        word_o = {unp_i.sign, f_norm_exp(unp_i.exp, unp_i.bias), f_pad_man(unp_i.man)};
      end
    endcase
  end

endmodule

// File: rtl/fp8w_widen.sv
module fp8w_widen
  import fp8w_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic             in_fmt,
  input  logic [IN_W-1:0]  in_data,
  output logic             out_valid,
  output logic [OUT_W-1:0] out_data,
  output logic             out_zero,
  output logic             out_sub,
  output logic             out_inf,
  output logic             out_nan
);

  fp8w_unp_t        unp_nx;
  fp8w_unp_t        unp_wx;
  fp8w_unp_t        unp_sel;
  logic [LZ_W-1:0]  lead_zeros;
  logic [OUT_W-1:0] word_next;
  fp8w_flags_t      flags_next;
  logic             load_en;
  logic             fmt_q;

  fp8w_fmt_dec #(
    .EXP_W(NX_EXP_W), .MAN_W(NX_MAN_W), .BIAS(NX_BIAS), .HAS_INF(1'b0)
  ) u_dec_nx (
    .byte_i(in_data),
    .unp_o (unp_nx)
  );

  fp8w_fmt_dec #(
    .EXP_W(WX_EXP_W), .MAN_W(WX_MAN_W), .BIAS(WX_BIAS), .HAS_INF(1'b1)
  ) u_dec_wx (
    .byte_i(in_data),
    .unp_o (unp_wx)
  );

  assign unp_sel = (in_fmt == FMT_EXP5) ? unp_wx : unp_nx;
  assign load_en = in_valid;

  fp8w_lzc #(.W(UMAN_W)) u_lzc (
    .vec_i(unp_sel.man),
    .lz_o (lead_zeros)
  );

  fp8w_pack u_pack (
    .unp_i  (unp_sel),
    .lz_i   (lead_zeros),
    .word_o (word_next),
    .flags_o(flags_next)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      out_zero  <= 1'b0;
      out_sub   <= 1'b0;
      out_inf   <= 1'b0;
      out_nan   <= 1'b0;
      fmt_q     <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (load_en) begin
        out_data <= word_next;
        out_zero <= flags_next.zero;
        out_sub  <= flags_next.sub;
        out_inf  <= flags_next.inf;
        out_nan  <= flags_next.nan;
        fmt_q    <= in_fmt;
      end
    end
  end

  // R8
  valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);

  // R8
  valid_drop_chk: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);

  // R9
  hold_data_chk: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> ($stable(out_data) && $stable({out_zero, out_sub, out_inf, out_nan})));

  // R10
  one_class_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $onehot0({out_zero, out_sub, out_inf, out_nan}));

  // R7
  no_inf_exp4_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && fmt_q == FMT_EXP4) |-> !out_inf);

  // R6
  nan_shape_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_nan) |-> (out_data[30:22] == 9'h1FF && out_data[21:0] == 22'h0));

  // R3
  sub_is_normal_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_sub) |-> (out_data[30:23] != 8'h00 && out_data[30:23] != 8'hFF));

  // R4
  zero_shape_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_zero) |-> (out_data[30:0] == 31'h0));

endmodule

// File: tb/sim_fp8w_widen.sv
`timescale 1ns/1ps
module sim_fp8w_widen;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic        in_fmt = 1'b0;
  logic [7:0]  in_data = 8'h00;
  logic        out_valid;
  logic [31:0] out_data;
  logic        out_zero, out_sub, out_inf, out_nan;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  fp8w_widen u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_fmt(in_fmt), .in_data(in_data),
    .out_valid(out_valid), .out_data(out_data), .out_zero(out_zero),
    .out_sub(out_sub), .out_inf(out_inf), .out_nan(out_nan)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  // Reference: value = sig * 2^sc, then renormalised; flags = {zero, sub, inf, nan}
  task automatic model(input logic fmt, input logic [7:0] b,
                       output logic [31:0] r, output logic [3:0] fl, output string tag);
    int ew, mw, bias, s, e, m, emax, sig, sc, p, ex;
    logic [31:0] man;
    ew = fmt ? 5 : 4;  mw = fmt ? 2 : 3;  bias = fmt ? 15 : 7;
    s = b[7];
    e = (int'(b) >> mw) & ((1 << ew) - 1);
    m = int'(b) & ((1 << mw) - 1);
    emax = (1 << ew) - 1;
    if (fmt && e == emax) begin
      if (m == 0) begin r = {s[0], 8'hFF, 23'h0}; fl = 4'b0010; tag = "R5"; end
      else        begin r = {s[0], 8'hFF, 1'b1, 22'h0}; fl = 4'b0001; tag = "R6"; end
    end else if (!fmt && e == 15 && m == 7) begin
      r = {s[0], 8'hFF, 1'b1, 22'h0}; fl = 4'b0001; tag = "R7";
    end else if (e == 0 && m == 0) begin
      r = {s[0], 31'h0}; fl = 4'b1000; tag = "R4";
    end else begin
      sig = (e == 0) ? m : ((1 << mw) | m);
      sc  = ((e == 0) ? 1 : e) - bias - mw;
      p = 0;
      for (int i = 0; i < 8; i++) if ((sig >> i) & 1) p = i;
      ex  = 127 + sc + p;
      man = 32'(sig - (1 << p)) << (23 - p);
      r   = {s[0], ex[7:0], man[22:0]};
      fl  = (e == 0) ? 4'b0100 : 4'b0000;
      if (e == 0)                 tag = "R3";
      else if (!fmt && e == 15)   tag = "R7";
      else                        tag = fmt ? "R2/R10" : "R1/R10";
    end
  endtask

  task automatic apply(input logic fmt, input logic [7:0] b);
    @(negedge clk);
    in_valid = 1'b1; in_fmt = fmt; in_data = b;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

  initial begin : main
    logic [31:0] er, last;
    logic [3:0]  ef;
    string       tag;

    // Reset, with valid held high: R8
    in_valid = 1'b1;
    repeat (3) @(negedge clk);
    check("R8 reset clears out_valid", {31'h0, out_valid}, 32'h0);
    @(negedge clk);
    rst = 1'b0; in_valid = 1'b0;
    @(negedge clk);
    check("R8 idle after reset", {31'h0, out_valid}, 32'h0);

    // Exhaustive sweep, both layouts: R1..R7, R10
    for (int f = 0; f < 2; f++) begin
      for (int v = 0; v < 256; v++) begin
        apply(f[0], v[7:0]);
        model(f[0], v[7:0], er, ef, tag);
        check({"R8 valid ", tag}, {31'h0, out_valid}, 32'h1);
        check(tag, out_data, er);
        check({tag, " flags"}, {28'h0, out_zero, out_sub, out_inf, out_nan}, {28'h0, ef});
        if (!f[0]) check("R7 no inf", {31'h0, out_inf}, 32'h0);
      end
    end

    // Explicit corner points
    apply(1'b0, 8'h7E);
    check("R7 max finite 448", out_data, 32'h43E00000);
    apply(1'b0, 8'hFF);
    check("R7 negative NaN", out_data, 32'hFFC00000);
    apply(1'b1, 8'hFC);
    check("R5 negative inf", out_data, 32'hFF800000);
    apply(1'b0, 8'h01);
    check("R3 smallest subnormal", out_data, 32'h3B000000);
    apply(1'b1, 8'h80);
    check("R4 negative zero", out_data, 32'h80000000);

    // Hold while idle: R9
    apply(1'b0, 8'h38);
    last = out_data;
    check("R1 one", last, 32'h3F800000);
    in_data = 8'hFF; in_fmt = 1'b1;
    @(negedge clk);
    check("R8 valid low", {31'h0, out_valid}, 32'h0);
    check("R9 data held", out_data, last);
    @(negedge clk);
    check("R9 data still held", out_data, last);
    check("R9 nan flag held low", {31'h0, out_nan}, 32'h0);

    // Back-to-back operands then reset mid-stream: R8
    @(negedge clk);
    in_valid = 1'b1; in_fmt = 1'b1; in_data = 8'h3C;
    @(negedge clk);
    check("R2 back-to-back first", out_data, 32'h3F800000);
    in_data = 8'h40;
    @(negedge clk);
    check("R2 back-to-back second", out_data, 32'h40000000);
    rst = 1'b1;
    @(negedge clk);
    check("R8 reset mid-stream", {31'h0, out_valid}, 32'h0);
    rst = 1'b0; in_valid = 1'b0;
    @(negedge clk);

    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

endmodule